// File: doc/BRIEF.md
# Four-Channel Countdown Timer with APB Register Access

This peripheral holds several independent 32-bit down-counters behind one APB slave port. Each channel sits in its own 64-byte register window. Software programs a start value, picks free-running or one-shot operation and switches the counter on. The channel then counts down once per clock and flags an expiry on its own interrupt line. A shared word at address zero shows the raw pending state of every channel at once.

An interrupt is acknowledged through a small handshake. Writing a one to the channel's acknowledge register starts a fixed two-cycle clear sequence, and a busy flag is visible to software for that time. Acknowledge writes are ignored while the flag is set, and an expiry that lands inside the window is kept rather than lost. A separate reload register copies the start value into the counter whenever it is written, whatever the data. A per-channel mask gates the interrupt line without touching the pending state.

Top module: `apb_quad_timer`

## Requirements
- R1: A read of address 0x00 returns the pending bit of channel n in bit n, with all higher bits zero.
- R2: Channel n's window starts at byte n*0x40. Inside a window, the following registers read back what was last written to them: 0x04 run mode (bit 0: 0 free-running, 1 one-shot), 0x08 start value, 0x10 enable (bit 0) and 0x24 mask (bit 0). Offsets that map to no register, the reload register 0x14 and offset 0x00 of any window but channel 0's all read zero.
- R3: While enabled, a non-zero counter at 0x18 drops by one on each clock. A step from 1 to 0 is an expiry, and it sets the channel's pending bit.
- R4: In free-running mode, an enabled counter that holds 0 takes the start value on the next clock, so expiries repeat every start value + 1 clocks.
- R5: In one-shot mode the counter stays at 0 after expiry. A write of 1 to enable while the count is 0 restarts it from the start value.
- R6: A write of any data to offset 0x14 copies the start value into the counter at that clock edge. This takes priority over counting. A write to 0x08 alone does not change the count.
- R7: Offset 0x20 reads the pending bit in bit 0 and the busy flag in bit 1. Writing 1 to bit 0 raises busy for exactly 2 clocks, and pending drops when busy drops. Writing 0 to bit 0 does nothing.
- R8: An acknowledge write while busy is set is ignored. An expiry during the busy window leaves pending set after busy drops.
- R9: irq_o[n] is 1 exactly when channel n is pending and its mask bit is 0.
- R10: Writing 0 to enable freezes the count at its current value.
- R11: After reset every register, counter, pending and busy bit is 0 and every interrupt line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Clock |
| presetn | input | 1 | Active-low synchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write (1) or read (0) |
| paddr | input | 8 | Byte address: channel index in bits 7:6, offset in bits 5:0 |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, combinational from paddr |
| irq_o | output | 4 | Per-channel interrupt lines |

## Verification
Register writes take effect on the clock edge of the APB access phase. Read data is combinational, so any read reflects the state after the previous edge. An expiry moves the pending bit and the interrupt line on the same edge as the count step from 1 to 0. An acknowledge shows busy for the two edges that follow its write, and pending falls together with busy on the second of them. The bench drives inputs on falling edges. It steps a behavioural model of every channel on each rising edge, compares all interrupt lines against the model on every falling edge, and checks each read in its access phase, where DUT and model have seen the same edges.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   localparam int WIN_W = 6;

   localparam logic [WIN_W-1:0] OFF_STAT = 6'h00;
   localparam logic [WIN_W-1:0] OFF_MODE = 6'h04;
   localparam logic [WIN_W-1:0] OFF_LOAD = 6'h08;
   localparam logic [WIN_W-1:0] OFF_EN   = 6'h10;
   localparam logic [WIN_W-1:0] OFF_RLD  = 6'h14;
   localparam logic [WIN_W-1:0] OFF_CNT  = 6'h18;
   localparam logic [WIN_W-1:0] OFF_ACK  = 6'h20;
   localparam logic [WIN_W-1:0] OFF_MASK = 6'h24;

   typedef enum logic {
      MODE_FREE = 1'b0,
      MODE_ONCE = 1'b1
   } run_mode_e;

   typedef struct packed {
      logic mode_wr;
      logic load_wr;
      logic en_wr;
      logic rld_wr;
      logic ack_wr;
      logic mask_wr;
   } chan_wr_t;
endpackage

// File: rtl/tmr_clr_seq.sv
module tmr_clr_seq #(
   parameter int CLR_CYCLES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic expire_i,
   input  logic ack_req_i,
   output logic pend_o,
   output logic busy_o
);
   localparam int BW = $clog2(CLR_CYCLES + 1);

   if (CLR_CYCLES < 2) begin : g_bad_clr
      $error("tmr_clr_seq: CLR_CYCLES must be at least 2");
   end

   logic [BW-1:0] busy_cnt;
   logic          late_q;
   logic          pend_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_cnt <= '0;
         late_q   <= 1'b0;
         pend_q   <= 1'b0;
      end else if (busy_cnt != '0) begin
         busy_cnt <= busy_cnt - BW'(1);
         if (busy_cnt == BW'(1)) begin
            pend_q <= late_q | expire_i;
            late_q <= 1'b0;
         end else if (expire_i) begin
            late_q <= 1'b1;
         end
      end else begin
         if (expire_i)  pend_q   <= 1'b1;
         if (ack_req_i) busy_cnt <= BW'(CLR_CYCLES);
      end
   end

   assign pend_o = pend_q;
   assign busy_o = (busy_cnt != '0);

   // R7: busy lasts more than one cycle once raised
   a_r7_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |=> busy_o);
   // R7: pending only falls at the end of a clear sequence
   a_r7_drop_at_end: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pend_q) |-> $past(busy_cnt) == BW'(1));
   // R8: an expiry recorded during the window survives the clear
   a_r8_late_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_cnt == BW'(1) && late_q) |=> pend_q);
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
   import tmr_pkg::*;
#(
   parameter int CNT_W      = 32,
   parameter int CLR_CYCLES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  chan_wr_t         wr_i,
   input  logic [31:0]      wdata_i,
   input  logic [WIN_W-1:0] roff_i,
   output logic [31:0]      rdata_o,
   output logic             pend_o,
   output logic             irq_o
);
   if (CNT_W < 2 || CNT_W > 32) begin : g_bad_w
      $error("tmr_channel: CNT_W must lie in 2..32");
   end

   run_mode_e        mode_q;
   logic [CNT_W-1:0] load_q;
   logic [CNT_W-1:0] cnt_q;
   logic             en_q;
   logic             mask_q;
   logic             busy;
   logic             pend;
   logic             expire;

   assign expire = en_q && !wr_i.rld_wr && !wr_i.en_wr && (cnt_q == CNT_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= MODE_FREE;
         load_q <= '0;
         en_q   <= 1'b0;
         mask_q <= 1'b0;
      end else begin
         if (wr_i.mode_wr) mode_q <= run_mode_e'(wdata_i[0]);
         if (wr_i.load_wr) load_q <= wdata_i[CNT_W-1:0];
         if (wr_i.en_wr)   en_q   <= wdata_i[0];
         if (wr_i.mask_wr) mask_q <= wdata_i[0];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (wr_i.rld_wr) begin
         cnt_q <= load_q;
      end else if (wr_i.en_wr) begin
         if (wdata_i[0] && cnt_q == '0) cnt_q <= load_q;
      end else if (en_q) begin
         if (cnt_q != '0)             cnt_q <= cnt_q - CNT_W'(1);
         else if (mode_q == MODE_FREE) cnt_q <= load_q;
      end
   end

   tmr_clr_seq #(.CLR_CYCLES(CLR_CYCLES)) u_clr (
      .clk      (clk),
      .rst_n    (rst_n),
      .expire_i (expire),
      .ack_req_i(wr_i.ack_wr && wdata_i[0]),
      .pend_o   (pend),
      .busy_o   (busy)
   );

   assign pend_o = pend;
   assign irq_o  = pend & ~mask_q;

   always_comb begin
      rdata_o = '0;
      unique case (roff_i)
         OFF_MODE: rdata_o = 32'(mode_q);
         OFF_LOAD: rdata_o = 32'(load_q);
         OFF_EN:   rdata_o = 32'(en_q);
         OFF_CNT:  rdata_o = 32'(cnt_q);
         OFF_ACK:  rdata_o = {30'd0, busy, pend};
         OFF_MASK: rdata_o = 32'(mask_q);
         default:  rdata_o = '0;
      endcase
   end

   // R3: one step down per clock while enabled
   a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q && cnt_q != '0 && !wr_i.rld_wr && !wr_i.en_wr)
      |=> cnt_q == $past(cnt_q) - CNT_W'(1));
   // R4: free-running reload from zero
   a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q && mode_q == MODE_FREE && cnt_q == '0 && !wr_i.rld_wr && !wr_i.en_wr)
      |=> cnt_q == $past(load_q));
   // R5: one-shot parks at zero
   a_r5_park: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q && mode_q == MODE_ONCE && cnt_q == '0 && !wr_i.rld_wr && !wr_i.en_wr)
      |=> cnt_q == '0);
   // R6: reload strobe copies the start value
   a_r6_reload: assert property (@(posedge clk) disable iff (!rst_n)
      wr_i.rld_wr |=> cnt_q == $past(load_q));
   // R10: disabled counter is frozen
   a_r10_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_q && !wr_i.rld_wr && !wr_i.en_wr) |=> $stable(cnt_q));
endmodule

// File: rtl/apb_quad_timer.sv
module apb_quad_timer
   import tmr_pkg::*;
#(
   parameter int NUM_CH     = 4,
   parameter int CNT_W      = 32,
   parameter int CLR_CYCLES = 2,
   localparam int CH_W      = $clog2(NUM_CH),
   localparam int ADDR_W    = WIN_W + CH_W
) (
   input  logic              pclk,
   input  logic              presetn,
   input  logic              psel,
   input  logic              penable,
   input  logic              pwrite,
   input  logic [ADDR_W-1:0] paddr,
   input  logic [31:0]       pwdata,
   output logic [31:0]       prdata,
   output logic [NUM_CH-1:0] irq_o
);
   if (NUM_CH < 2 || NUM_CH > 32 || (1 << CH_W) != NUM_CH) begin : g_bad_n
      $error("apb_quad_timer: NUM_CH must be a power of two in 2..32");
   end

   logic             wr_acc;
   logic [CH_W-1:0]  ch_sel;
   logic [WIN_W-1:0] off;
   logic [31:0]      ch_rdata [NUM_CH];
   logic [NUM_CH-1:0] pend_vec;

   assign wr_acc = psel & penable & pwrite;
   assign ch_sel = paddr[ADDR_W-1:WIN_W];
   assign off    = paddr[WIN_W-1:0];

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      chan_wr_t wr;
      logic     hit;
      assign hit        = wr_acc && (ch_sel == CH_W'(c));
      assign wr.mode_wr = hit && (off == OFF_MODE);
      assign wr.load_wr = hit && (off == OFF_LOAD);
      assign wr.en_wr   = hit && (off == OFF_EN);
      assign wr.rld_wr  = hit && (off == OFF_RLD);
      assign wr.ack_wr  = hit && (off == OFF_ACK);
      assign wr.mask_wr = hit && (off == OFF_MASK);

      tmr_channel #(.CNT_W(CNT_W), .CLR_CYCLES(CLR_CYCLES)) u_chan (
         .clk    (pclk),
         .rst_n  (presetn),
         .wr_i   (wr),
         .wdata_i(pwdata),
         .roff_i (off),
         .rdata_o(ch_rdata[c]),
         .pend_o (pend_vec[c]),
         .irq_o  (irq_o[c])
      );
   end

   always_comb begin
      if (ch_sel == '0 && off == OFF_STAT) prdata = 32'(pend_vec);
      else                                 prdata = ch_rdata[ch_sel];
   end
endmodule

// File: tb/tb_apb_quad_timer.sv
module tb_apb_quad_timer;
   localparam int NCH = 4;

   logic        pclk = 1'b0;
   logic        presetn = 1'b0;
   logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
   logic [7:0]  paddr = '0;
   logic [31:0] pwdata = '0;
   logic [31:0] prdata;
   logic [NCH-1:0] irq_o;

   int checks = 0;
   int errors = 0;

   always #2.5 pclk = ~pclk;

   apb_quad_timer dut (
      .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
      .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
      .irq_o(irq_o)
   );

   // reference model
   int unsigned m_load [NCH];
   int unsigned m_cnt  [NCH];
   bit m_mode [NCH], m_en [NCH], m_mask [NCH], m_pend [NCH], m_late [NCH];
   int m_busy [NCH];

   always @(posedge pclk) begin
      if (!presetn) begin
         for (int c = 0; c < NCH; c++) begin
            m_load[c] = 0; m_cnt[c] = 0; m_mode[c] = 0; m_en[c] = 0;
            m_mask[c] = 0; m_pend[c] = 0; m_late[c] = 0; m_busy[c] = 0;
         end
      end else begin
         for (int c = 0; c < NCH; c++) begin
            bit wr, exp;
            int o;
            wr = psel && penable && pwrite && (int'(paddr[7:6]) == c);
            o  = int'(paddr[5:0]);
            exp = m_en[c] && !(wr && (o == 'h14 || o == 'h10)) && m_cnt[c] == 1;
            if (wr && o == 'h14) m_cnt[c] = m_load[c];
            else if (wr && o == 'h10) begin
               if (pwdata[0] && m_cnt[c] == 0) m_cnt[c] = m_load[c];
            end else if (m_en[c]) begin
               if (m_cnt[c] != 0) m_cnt[c] = m_cnt[c] - 1;
               else if (!m_mode[c]) m_cnt[c] = m_load[c];
            end
            if (m_busy[c] > 0) begin
               m_late[c] = m_late[c] | exp;
               m_busy[c] = m_busy[c] - 1;
               if (m_busy[c] == 0) begin m_pend[c] = m_late[c]; m_late[c] = 0; end
            end else begin
               if (exp) m_pend[c] = 1;
               if (wr && o == 'h20 && pwdata[0]) m_busy[c] = 2;
            end
            if (wr && o == 'h04) m_mode[c] = pwdata[0];
            if (wr && o == 'h08) m_load[c] = pwdata;
            if (wr && o == 'h10) m_en[c]   = pwdata[0];
            if (wr && o == 'h24) m_mask[c] = pwdata[0];
         end
      end
   end

   function automatic logic [31:0] m_read(logic [7:0] a);
      int c = int'(a[7:6]);
      case (int'(a[5:0]))
         'h00: begin
            logic [31:0] s = '0;
            if (c == 0) for (int k = 0; k < NCH; k++) s[k] = m_pend[k];
            return s;
         end
         'h04: return 32'(m_mode[c]);
         'h08: return m_load[c];
         'h10: return 32'(m_en[c]);
         'h18: return m_cnt[c];
         'h20: return {30'd0, m_busy[c] != 0, m_pend[c]};
         'h24: return 32'(m_mask[c]);
         default: return '0;
      endcase
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
      end
   endtask

   // R9: interrupt lines against model on every cycle
   always @(negedge pclk) begin
      if (presetn) begin
         logic [NCH-1:0] e;
         for (int c = 0; c < NCH; c++) e[c] = m_pend[c] & ~m_mask[c];
         chk("R9 irq", 32'(irq_o), 32'(e));
      end
   end

   // tasks are entered at a falling edge
   task automatic apb_wr(logic [7:0] a, logic [31:0] d);
      psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
      @(negedge pclk); penable = 1;
      @(negedge pclk); psel = 0; penable = 0; pwrite = 0;
   endtask

   task automatic apb_rd(logic [7:0] a, string tag);
      psel = 1; penable = 0; pwrite = 0; paddr = a;
      @(negedge pclk); penable = 1;
      chk(tag, prdata, m_read(a));
      @(negedge pclk); psel = 0; penable = 0;
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge pclk);
   endtask

   initial begin
      repeat (100000) @(posedge pclk);
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge pclk);
      presetn = 1;
      // R11 reset state
      chk("R11 irq", 32'(irq_o), 32'd0);
      for (int c = 0; c < NCH; c++) begin
         apb_rd(8'(c * 64 + 'h18), "R11 count");
         apb_rd(8'(c * 64 + 'h20), "R11 ack");
      end
      chk("R11 status", prdata, 32'd0);
      apb_rd(8'h00, "R1 status reset");

      // R2 readback and window placement
      apb_wr(8'h48, 32'h1234_5678);
      apb_rd(8'h48, "R2 load ch1");
      apb_rd(8'h08, "R2 load ch0 untouched");
      apb_wr(8'hE4, 32'h1);
      apb_rd(8'hE4, "R2 mask ch3");
      apb_wr(8'hE4, 32'h0);
      apb_rd(8'hCC, "R2 unmapped");
      apb_rd(8'hD4, "R2 reload reads zero");
      apb_rd(8'hC0, "R2 offset0 ch3");
      apb_rd(8'h58, "R6 load write keeps count");

      // R3/R4 free-running channel 0
      apb_wr(8'h08, 32'd5);
      apb_wr(8'h04, 32'd0);
      apb_wr(8'h14, 32'd7);
      apb_wr(8'h10, 32'd1);
      apb_rd(8'h18, "R3 count step");
      apb_rd(8'h18, "R3 count step again");
      idle(9);
      apb_rd(8'h18, "R4 wrapped count");
      apb_rd(8'h00, "R1 status ch0");
      // R7 clear handshake and R8 ignored write
      apb_wr(8'h20, 32'h1);
      apb_rd(8'h20, "R7 busy visible");
      apb_rd(8'h20, "R7 after clear");
      apb_wr(8'h20, 32'h1);
      apb_wr(8'h20, 32'h1);
      apb_rd(8'h20, "R8 ack while busy");
      idle(7);
      apb_wr(8'h20, 32'h0);
      apb_rd(8'h20, "R7 zero write no effect");
      // R9 mask
      apb_wr(8'h24, 32'h1);
      idle(8);
      apb_rd(8'h24, "R9 mask set");
      apb_wr(8'h24, 32'h0);
      // R10 disable freezes
      apb_wr(8'h10, 32'd0);
      apb_rd(8'h18, "R10 frozen a");
      idle(3);
      apb_rd(8'h18, "R10 frozen b");

      // R5/R6 one-shot channel 1
      apb_wr(8'h48, 32'd3);
      apb_wr(8'h44, 32'd1);
      apb_wr(8'h54, 32'd0);
      apb_wr(8'h50, 32'd1);
      idle(8);
      apb_rd(8'h58, "R5 parked at zero");
      apb_rd(8'h60, "R5 pending");
      apb_wr(8'h54, 32'd1);
      apb_rd(8'h58, "R6 reload strobe");
      idle(6);
      apb_rd(8'h58, "R5 parked again");
      apb_wr(8'h50, 32'd1);
      apb_rd(8'h58, "R5 enable restart");
      idle(6);

      // R8 expiry inside clear windows, channel 2 period 3
      apb_wr(8'h88, 32'd2);
      apb_wr(8'h94, 32'd0);
      apb_wr(8'h90, 32'd1);
      for (int k = 0; k < 6; k++) begin
         apb_wr(8'hA0, 32'h1);
         apb_rd(8'hA0, "R8 clear vs expiry");
         idle(k % 3);
      end
      apb_rd(8'h00, "R1 status multi");
      apb_rd(8'h98, "R3 count ch2");

      // channel 3 load zero in free mode
      apb_wr(8'hD0, 32'd1);
      idle(4);
      apb_rd(8'hD8, "R4 zero load");
      apb_rd(8'h00, "R1 status final");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule